// File: doc/BRIEF.md
# Two-Master Priority Bus Arbiter

This block shares one bus between a data-side master and an instruction-side master. Each master drives a request, a two-bit priority and an abort line. When nothing is granted, the arbiter picks a winner from the masters that are requesting. It registers that grant and holds it until the slave accepts the address, the winner aborts, or the winner withdraws its request. The slave's address acknowledge is routed only to the granted master.

After the slave accepts an address, the block tracks that transfer until the slave reports completion. During that time it routes read-data acknowledges to the master that owns the transfer. Sometimes a master aborts in the same cycle in which the slave accepts its address. In that case the arbiter raises a cancel strobe toward the slave and absorbs every read-data acknowledge for that transfer, so the aborting master never sees one.

Top module: `bus_arb2`

## Requirements
- R1: While `rst_n` is low at a clock edge, every grant and acknowledge output is 0 after that edge. Round-robin state returns to "data side next".
- R2: When no grant is held and no master has a valid request (request high and abort low), no grant is output in the next cycle. With at least one valid request, a grant appears one cycle later.
- R3: When both masters are valid and their priorities differ, the numerically larger priority (00 lowest, 11 highest) wins.
- R4: When both priorities are equal and their bit 0 is 1 (01 or 11), the data side wins.
- R5: When both priorities are equal with bit 0 equal to 0 (00 or 10), the winner alternates between the two masters. The first such tie after reset goes to the data side.
- R6: A grant is held while the granted master keeps requesting, does not abort, and sees no address acknowledge. Any of those three events releases it at the next edge. The cycle after a release always shows no grant, and a new decision is made in that cycle.
- R7: `s_addr_ack` is passed, in the same cycle, only to the master that currently holds the grant. It is passed to neither master when there is no grant.
- R8: An abort input has no effect while its master's request is low. That holds at arbitration, while the master holds the grant, and when the address acknowledge arrives.
- R9: `s_cancel` is 1 exactly in a cycle where the granted master has request and abort both high and `s_addr_ack` is 1.
- R10: After a cancelled acceptance, every `s_rd_ack` is absorbed and reaches neither master until `s_rd_done`. A later accepted transfer is forwarded normally.
- R11: After an uncancelled acceptance, `s_rd_ack` is forwarded to the accepting master until `s_rd_done`. A new acceptance replaces the tracked transfer even in the same cycle as `s_rd_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| d_req | input | 1 | Data-side request |
| d_pri | input | 2 | Data-side priority, 11 highest |
| d_abort | input | 1 | Data-side abort, meaningful only with d_req |
| i_req | input | 1 | Instruction-side request |
| i_pri | input | 2 | Instruction-side priority, 11 highest |
| i_abort | input | 1 | Instruction-side abort, meaningful only with i_req |
| s_addr_ack | input | 1 | Slave accepts the granted address |
| s_rd_ack | input | 1 | Slave read-data acknowledge |
| s_rd_done | input | 1 | Slave finished the tracked transfer |
| d_gnt | output | 1 | Grant to data side |
| i_gnt | output | 1 | Grant to instruction side |
| d_addr_ack | output | 1 | Address acknowledge to data side |
| i_addr_ack | output | 1 | Address acknowledge to instruction side |
| d_rd_ack | output | 1 | Read-data acknowledge to data side |
| i_rd_ack | output | 1 | Read-data acknowledge to instruction side |
| s_cancel | output | 1 | Tells the slave to stop an accepted-but-aborted transfer |

## Verification
The race of interest is an abort from the granted master landing in the same cycle as the slave's address acknowledge. The bench drives both in one cycle and then sends several read-data acknowledges before completion. It expects the cancel strobe in that cycle, a release of the grant, and silence on both read-acknowledge outputs until done. A second overlap, a tie between masters that coincides with a release, is checked by comparing each following grant with a behavioural model on every clock.

// File: rtl/bus_arb2_pkg.sv
// Shared types for the two-master arbiter.
// Assumes exactly two masters: a data side and an instruction side.
package bus_arb2_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_D    = 2'd1,
        SEL_I    = 2'd2
    } sel_e;
endpackage

// File: rtl/arb2_pick.sv
// Combinational winner selection between two valid requests.
// Larger priority wins. Equal priority with bit 0 set goes to the data side.
// Other ties follow the round-robin turn. Assumes valid already excludes aborts.
module arb2_pick
    import bus_arb2_pkg::*;
#(
    parameter int PRI_W = 2
) (
    input  logic             d_valid,
    input  logic             i_valid,
    input  logic [PRI_W-1:0] d_pri,
    input  logic [PRI_W-1:0] i_pri,
    input  logic             rr_i_turn,
    output sel_e             win,
    output logic             used_rr
);
    localparam int TIE_BIT = 0;

    // Choose the winner for this cycle.
    always_comb begin
        win     = SEL_NONE;
        used_rr = 1'b0;
        if (d_valid && !i_valid) begin
            win = SEL_D;
        end else if (i_valid && !d_valid) begin
            win = SEL_I;
        end else if (d_valid && i_valid) begin
            if (d_pri > i_pri) begin
                win = SEL_D;
            end else if (i_pri > d_pri) begin
                win = SEL_I;
            end else if (d_pri[TIE_BIT]) begin
                win = SEL_D;
            end else begin
                used_rr = 1'b1;
                win     = rr_i_turn ? SEL_I : SEL_D;
            end
        end
    end
endmodule

// File: rtl/arb2_grant.sv
// Grant register and round-robin turn.
// Decides only when idle, then holds until address acknowledge,
// abort or withdrawn request. Assumes g_req/g_abort are the granted master's lines.
module arb2_grant
    import bus_arb2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sel_e win,
    input  logic used_rr,
    input  logic any_valid,
    input  logic g_req,
    input  logic g_abort,
    input  logic addr_ack,
    output sel_e gnt_q,
    output logic rr_i_turn
);
    logic release_now;

    // Release condition for a held grant.
    always_comb begin
        release_now = addr_ack || !g_req || g_abort;
    end

    // Grant state: decide when idle, drop on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q <= SEL_NONE;
        end else if (gnt_q == SEL_NONE) begin
            gnt_q <= win;
        end else if (release_now) begin
            gnt_q <= SEL_NONE;
        end
    end

    // Round-robin turn flips after each plain-tie decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_i_turn <= 1'b0;
        end else if (gnt_q == SEL_NONE && used_rr) begin
            rr_i_turn <= (win == SEL_D);
        end
    end

    p_idle_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q == SEL_NONE && !any_valid) |=> (gnt_q == SEL_NONE));

    p_grant_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q != SEL_NONE && g_req && !g_abort && !addr_ack) |=> $stable(gnt_q));

    p_release_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q != SEL_NONE && addr_ack) |=> (gnt_q == SEL_NONE));
endmodule

// File: rtl/arb2_rdtrack.sv
// Tracks the one accepted transfer and routes read-data acknowledges.
// A cancelled acceptance sets a drop flag that absorbs acks until done.
// Assumes the slave completes a transfer before it reuses the read path.
module arb2_rdtrack
    import bus_arb2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sel_e gnt,
    input  logic accept,
    input  logic kill,
    input  logic rd_ack,
    input  logic rd_done,
    output logic d_rd_ack,
    output logic i_rd_ack
);
    logic busy_q;
    logic drop_q;
    sel_e own_q;

    // Transfer tracking: a new acceptance wins over completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            drop_q <= 1'b0;
            own_q  <= SEL_NONE;
        end else if (accept) begin
            busy_q <= 1'b1;
            drop_q <= kill;
            own_q  <= gnt;
        end else if (rd_done && busy_q) begin
            busy_q <= 1'b0;
            drop_q <= 1'b0;
        end
    end

    // Route read acks to the owner unless dropped.
    always_comb begin
        d_rd_ack = rd_ack && busy_q && !drop_q && (own_q == SEL_D);
        i_rd_ack = rd_ack && busy_q && !drop_q && (own_q == SEL_I);
    end

    p_kill_absorbs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !(d_rd_ack || i_rd_ack));

    p_accept_forwards_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !kill) |=> (!rd_ack || d_rd_ack || i_rd_ack));
endmodule

// File: rtl/bus_arb2.sv
// Top of the two-master priority arbiter.
// Qualifies requests with aborts, picks and holds a grant, routes the
// address acknowledge, and flags abort/acknowledge races to the slave.
module bus_arb2
    import bus_arb2_pkg::*;
#(
    parameter int PRI_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d_req,
    input  logic [PRI_W-1:0] d_pri,
    input  logic             d_abort,
    input  logic             i_req,
    input  logic [PRI_W-1:0] i_pri,
    input  logic             i_abort,
    input  logic             s_addr_ack,
    input  logic             s_rd_ack,
    input  logic             s_rd_done,
    output logic             d_gnt,
    output logic             i_gnt,
    output logic             d_addr_ack,
    output logic             i_addr_ack,
    output logic             d_rd_ack,
    output logic             i_rd_ack,
    output logic             s_cancel
);
    logic d_valid, i_valid, used_rr, rr_i_turn;
    logic g_req, g_abort, accept;
    sel_e win, gnt;

    // Requests count only when not being aborted.
    always_comb begin
        d_valid = d_req && !d_abort;
        i_valid = i_req && !i_abort;
    end

    arb2_pick #(.PRI_W(PRI_W)) u_pick (
        .d_valid   (d_valid),
        .i_valid   (i_valid),
        .d_pri     (d_pri),
        .i_pri     (i_pri),
        .rr_i_turn (rr_i_turn),
        .win       (win),
        .used_rr   (used_rr)
    );

    // Lines of the master that holds the grant; abort counts only with request.
    always_comb begin
        g_req   = 1'b0;
        g_abort = 1'b0;
        if (gnt == SEL_D) begin
            g_req   = d_req;
            g_abort = d_req && d_abort;
        end else if (gnt == SEL_I) begin
            g_req   = i_req;
            g_abort = i_req && i_abort;
        end
    end

    arb2_grant u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .win       (win),
        .used_rr   (used_rr),
        .any_valid (d_valid || i_valid),
        .g_req     (g_req),
        .g_abort   (g_abort),
        .addr_ack  (s_addr_ack),
        .gnt_q     (gnt),
        .rr_i_turn (rr_i_turn)
    );

    // Grant decode, acknowledge routing and race strobe.
    always_comb begin
        d_gnt      = (gnt == SEL_D);
        i_gnt      = (gnt == SEL_I);
        d_addr_ack = s_addr_ack && d_gnt;
        i_addr_ack = s_addr_ack && i_gnt;
        accept     = s_addr_ack && (gnt != SEL_NONE);
        s_cancel   = accept && g_abort;
    end

    arb2_rdtrack u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .gnt      (gnt),
        .accept   (accept),
        .kill     (s_cancel),
        .rd_ack   (s_rd_ack),
        .rd_done  (s_rd_done),
        .d_rd_ack (d_rd_ack),
        .i_rd_ack (i_rd_ack)
    );

    p_cancel_needs_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_cancel |-> (s_addr_ack && (d_gnt || i_gnt)));

    p_ack_routed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_addr_ack && !d_gnt && !i_gnt) |-> !(d_addr_ack || i_addr_ack));

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !(d_gnt || i_gnt));
endmodule

// File: tb/bus_arb2_test.sv
// Bench: behavioural per-cycle reference model compared on every clock.
module bus_arb2_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic d_req = 0, d_abort = 0, i_req = 0, i_abort = 0;
    logic [1:0] d_pri = 0, i_pri = 0;
    logic s_addr_ack = 0, s_rd_ack = 0, s_rd_done = 0;
    logic d_gnt, i_gnt, d_addr_ack, i_addr_ack, d_rd_ack, i_rd_ack, s_cancel;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;
    string cur = "R1";

    // model state: 0 none, 1 data, 2 instruction
    int m_g = 0;
    int m_turn_i = 0;
    int m_busy = 0;
    int m_own = 0;
    int m_drop = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_arb2 uut (
        .clk(clk), .rst_n(rst_n),
        .d_req(d_req), .d_pri(d_pri), .d_abort(d_abort),
        .i_req(i_req), .i_pri(i_pri), .i_abort(i_abort),
        .s_addr_ack(s_addr_ack), .s_rd_ack(s_rd_ack), .s_rd_done(s_rd_done),
        .d_gnt(d_gnt), .i_gnt(i_gnt), .d_addr_ack(d_addr_ack), .i_addr_ack(i_addr_ack),
        .d_rd_ack(d_rd_ack), .i_rd_ack(i_rd_ack), .s_cancel(s_cancel)
    );

    task automatic chk(input string name, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", cur, name, got, exp, $time);
        end
    endtask

    function automatic int greq();
        if (m_g == 1) return int'(d_req);
        if (m_g == 2) return int'(i_req);
        return 0;
    endfunction

    function automatic int gabt();
        if (m_g == 1) return int'(d_req && d_abort);
        if (m_g == 2) return int'(i_req && i_abort);
        return 0;
    endfunction

    task automatic compare();
        int rdok;
        rdok = (s_rd_ack && m_busy == 1 && m_drop == 0) ? 1 : 0;
        chk("d_gnt", d_gnt, m_g == 1);
        chk("i_gnt", i_gnt, m_g == 2);
        chk("d_addr_ack", d_addr_ack, s_addr_ack && m_g == 1);
        chk("i_addr_ack", i_addr_ack, s_addr_ack && m_g == 2);
        chk("s_cancel", s_cancel, s_addr_ack && m_g != 0 && gabt() == 1);
        chk("d_rd_ack", d_rd_ack, rdok == 1 && m_own == 1);
        chk("i_rd_ack", i_rd_ack, rdok == 1 && m_own == 2);
    endtask

    task automatic model_step();
        int dv, iv, w, tie;
        if (!rst_n) begin
            m_g = 0; m_turn_i = 0; m_busy = 0; m_own = 0; m_drop = 0;
            return;
        end
        if (m_g != 0 && s_addr_ack) begin
            m_busy = 1; m_own = m_g; m_drop = gabt();
        end else if (s_rd_done && m_busy == 1) begin
            m_busy = 0; m_drop = 0;
        end
        if (m_g == 0) begin
            dv = (d_req && !d_abort) ? 1 : 0;
            iv = (i_req && !i_abort) ? 1 : 0;
            w = 0; tie = 0;
            if (dv == 1 && iv == 0) w = 1;
            else if (iv == 1 && dv == 0) w = 2;
            else if (dv == 1 && iv == 1) begin
                if (int'(d_pri) > int'(i_pri)) w = 1;
                else if (int'(i_pri) > int'(d_pri)) w = 2;
                else if (d_pri % 2 == 1) w = 1;
                else begin tie = 1; w = (m_turn_i == 1) ? 2 : 1; end
            end
            if (tie == 1) m_turn_i = (w == 1) ? 1 : 0;
            m_g = w;
        end else if (s_addr_ack || greq() == 0 || gabt() == 1) begin
            m_g = 0;
        end
    endtask

    // One cycle: inputs already set at the falling edge.
    task automatic tick();
        #1;
        compare();
        model_step();
        @(negedge clk);
    endtask

    task automatic drive(input logic dr, input logic [1:0] dp, input logic da,
                         input logic ir, input logic [1:0] ip, input logic ia,
                         input logic aa, input logic ra, input logic rd);
        d_req = dr; d_pri = dp; d_abort = da;
        i_req = ir; i_pri = ip; i_abort = ia;
        s_addr_ack = aa; s_rd_ack = ra; s_rd_done = rd;
        tick();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // Tie between both at given priorities until grant, then acknowledge.
    task automatic contend(input logic [1:0] dp, input logic [1:0] ip);
        drive(1, dp, 0, 1, ip, 0, 0, 0, 0);
        drive(1, dp, 0, 1, ip, 0, 1, 0, 0);
        idle(1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done_flag) begin
            done_flag = 1;
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset, even with requests present
        cur = "R1";
        drive(1, 3, 0, 1, 3, 0, 0, 0, 0);
        drive(1, 3, 0, 1, 3, 0, 1, 1, 0);
        rst_n = 1'b1;
        // R2: idle gives no grant; lone request granted next cycle
        cur = "R2";
        idle(3);
        drive(0, 0, 1, 0, 0, 1, 0, 0, 0);
        idle(1);
        // R7 R11: data transfer with acknowledge and read data
        cur = "R7";
        drive(1, 1, 0, 0, 0, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0, 0, 1, 0, 0);
        cur = "R11";
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0);
        cur = "R7";
        drive(0, 0, 0, 0, 0, 0, 1, 0, 0);
        // R3: numeric priority
        cur = "R3";
        contend(2'b01, 2'b10);
        contend(2'b11, 2'b10);
        contend(2'b00, 2'b01);
        // R4: tie with bit 0 set favours data side
        cur = "R4";
        contend(2'b11, 2'b11);
        contend(2'b01, 2'b01);
        // R5: plain ties alternate
        cur = "R5";
        contend(2'b00, 2'b00);
        contend(2'b10, 2'b10);
        contend(2'b00, 2'b00);
        contend(2'b10, 2'b10);
        // R6: hold, then release by abort and by withdrawal
        cur = "R6";
        drive(0, 0, 0, 1, 2, 0, 0, 0, 0);
        drive(1, 3, 0, 1, 2, 0, 0, 0, 0);
        drive(1, 3, 0, 1, 2, 0, 0, 0, 0);
        drive(1, 3, 0, 1, 2, 1, 0, 0, 0);
        drive(1, 3, 0, 0, 2, 0, 0, 0, 0);
        drive(0, 3, 0, 0, 0, 0, 0, 0, 0);
        idle(1);
        // R8: aborts without request are ignored
        cur = "R8";
        drive(0, 0, 1, 1, 0, 0, 0, 0, 0);
        drive(0, 0, 1, 1, 0, 0, 1, 0, 0);
        drive(0, 0, 1, 0, 0, 1, 0, 1, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 1);
        drive(1, 1, 0, 0, 0, 0, 0, 0, 0);
        drive(0, 1, 1, 0, 0, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 1);
        // R9 R10: abort races acknowledge
        cur = "R9";
        drive(1, 2, 0, 0, 0, 0, 0, 0, 0);
        drive(1, 2, 1, 0, 0, 0, 1, 0, 0);
        cur = "R10";
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0);
        drive(0, 0, 0, 1, 1, 0, 0, 1, 0);
        drive(0, 0, 0, 1, 1, 0, 0, 1, 0);
        drive(0, 0, 0, 1, 1, 0, 0, 1, 1);
        drive(0, 0, 0, 1, 1, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0);
        // R11: new acceptance in the same cycle as done
        cur = "R11";
        drive(1, 0, 0, 0, 0, 0, 0, 0, 1);
        drive(1, 0, 0, 0, 0, 0, 1, 1, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R9 R10 on instruction side
        cur = "R9";
        drive(0, 0, 0, 1, 3, 0, 0, 0, 0);
        drive(1, 0, 0, 1, 3, 1, 1, 0, 0);
        cur = "R10";
        drive(1, 0, 0, 0, 0, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 0, 0, 0, 1, 1);
        idle(2);
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule